// File: doc/BRIEF.md
# Four-Level Carrier PWM Modulator with Capacitor Balancing

This block produces the switching decisions for one three-phase inverter whose legs each give four voltage levels from a DC link split by three series capacitors. At every valley of one triangular carrier, it samples three signed phase references, the upper, middle and lower capacitor voltages, and the bus voltage. From these samples it computes the modulating signals for the whole carrier period that follows. A common offset is added to all three phases. When the upper capacitor holds at least as much voltage as the lower one, the offset drives the highest reference to the positive rail. Otherwise it drives the lowest reference to the negative rail. A proportional-integral term tries to hold the middle capacitor at one third of the bus. It does so by moving only the middle one of the three level comparisons of each phase.

Each phase keeps three shifted copies of its modulating signal. Each copy is compared with the shared carrier, which gives three comparator bits per phase. The number of bits that are set is the selected output level, from 0 to 3. The carrier half-period is an input, so the same logic serves any switching frequency. For example, 5000 cycles of a 100 MHz clock give a 10 kHz carrier. References use the carrier's own scale: full scale is three times the half-period.

Top module: `pwm4_mod`

## Requirements
- R1: The carrier count rises by one per clock from 0 to carr_half, then falls by one per clock back to 0, so one period is 2·carr_half cycles. The centred carrier value is 2·count − carr_half, and this single carrier feeds all nine comparisons.
- R2: For phase p (a=0, b=1, c=2) with modulating signal m and middle shift s: cmp_o[3p] compares the lower copy m+2·carr_half, cmp_o[3p+1] compares the middle copy m+s, and cmp_o[3p+2] compares the upper copy m−2·carr_half. Each bit is 1 when its copy is strictly greater than the carrier, and it appears one clock after the carrier count it was compared with.
- R3: When v_up ≥ v_lo at the sample, the common offset is 3·carr_half minus the largest of the three references.
- R4: When v_up < v_lo at the sample, the common offset is −3·carr_half minus the smallest of the three references.
- R5: The one offset computed per sample is added to all three phase references.
- R6: Each reference plus offset is clamped to ±3·carr_half. clip_o is 1 for the carrier period following a sample in which any phase was clamped, and 0 otherwise.
- R7: The error is v_bus − 3·v_mid. At each sample, the integrator adds error>>>KI_SH and is clamped to ±carr_half. The middle shift is (error>>>KP_SH) plus the integrator, clamped to ±carr_half, so a positive error raises the middle copy. With zero error the integrator keeps its value.
- R8: Inputs are sampled only when the count is 0 and rising. Input changes between two such samples have no effect on the outputs.
- R9: A synchronous reset drives cmp_o, lvl_o and clip_o to 0 on the next clock, clears the integrator and restarts the carrier at 0 rising. The first sample is taken at the first clock after reset is released.
- R10: lvl_o[2p+1:2p] equals the number of set bits among cmp_o[3p+2:3p].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| carr_half | input | CW | Carrier half-period in clocks; also the reference scale (full scale = 3·carr_half) |
| ref_a | input | DW | Signed phase a reference |
| ref_b | input | DW | Signed phase b reference |
| ref_c | input | DW | Signed phase c reference |
| v_up | input | DW | Upper capacitor voltage |
| v_mid | input | DW | Middle capacitor voltage |
| v_lo | input | DW | Lower capacitor voltage |
| v_bus | input | DW | Total DC-link voltage |
| cmp_o | output | 9 | Comparator bits, three per phase, bit 3p = lower copy |
| lvl_o | output | 6 | Selected level per phase, two bits each |
| clip_o | output | 1 | A modulating signal was clamped at the last sample |

## Verification
Some properties are checked on every cycle. The comparator bits of each phase always form a thermometer code. After a sample, one phase sits exactly on the positive or negative rail, on the side chosen by the two outer capacitor voltages. The modulating signals and the middle shift stay within their clamp limits. The carrier count never exceeds the half-period. Reset clears the outputs.

Other behaviours can only be shown by the bench's scenarios. It checks the exact duty of every bit for a range of reference patterns and both offset choices. It checks that the clip flag matches the clamping case. It checks that inputs changed between two valleys are ignored. It checks that the integrator saturates, holds its value at zero error, reverses when the error reverses, and is cleared by reset.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    localparam int NPH = 3;
    localparam int NCP = 3;
    typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/pwm4_carrier.sv
module pwm4_carrier
    import pwm4_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] half_i,
    output logic [CW-1:0] cnt_o,
    output logic          valley_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        dir_e          dir;
    } cst_t;

    cst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.dir == DIR_UP) begin
            if (({1'b0, st_q.cnt} + (CW+1)'(1)) >= {1'b0, half_i}) begin
                st_d.cnt = half_i;
                st_d.dir = DIR_DOWN;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else begin
            if (st_q.cnt > half_i) begin
                st_d.cnt = half_i;
            end else if (st_q.cnt <= CW'(1)) begin
                st_d.cnt = '0;
                st_d.dir = DIR_UP;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
        if (rst) begin
            st_d.cnt = '0;
            st_d.dir = DIR_UP;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign valley_o = (st_q.cnt == '0) && (st_q.dir == DIR_UP);

    // R1: the count never leaves the range set by the half-period
    a_r1_count_in_range: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt <= half_i) |=> (st_q.cnt <= $past(half_i)));
endmodule

// File: rtl/pwm4_zseq.sv
module pwm4_zseq #(
    parameter int WW = 20
) (
    input  logic signed [WW-1:0] ref_a_i,
    input  logic signed [WW-1:0] ref_b_i,
    input  logic signed [WW-1:0] ref_c_i,
    input  logic signed [WW-1:0] v_up_i,
    input  logic signed [WW-1:0] v_lo_i,
    input  logic signed [WW-1:0] one_i,
    output logic signed [WW-1:0] zs_o
);
    logic signed [WW-1:0] mx, mn;

    always_comb begin
        mx = ref_a_i;
        if (ref_b_i > mx) mx = ref_b_i;
        if (ref_c_i > mx) mx = ref_c_i;
        mn = ref_a_i;
        if (ref_b_i < mn) mn = ref_b_i;
        if (ref_c_i < mn) mn = ref_c_i;
        if (v_up_i >= v_lo_i) zs_o = one_i - mx;
        else                  zs_o = -one_i - mn;
    end
endmodule

// File: rtl/pwm4_pi.sv
module pwm4_pi #(
    parameter int WW    = 20,
    parameter int KP_SH = 3,
    parameter int KI_SH = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valley_i,
    input  logic signed [WW-1:0] v_bus_i,
    input  logic signed [WW-1:0] v_mid_i,
    input  logic signed [WW-1:0] half_i,
    output logic signed [WW-1:0] pi_o
);
    typedef struct packed {
        logic [WW-1:0] integ;
        logic [WW-1:0] pi;
    } pst_t;

    pst_t st_d, st_q;
    logic signed [WW-1:0] err, i_n, p_n;

    always_comb begin
        st_d = st_q;
        err  = v_bus_i - ((v_mid_i <<< 1) + v_mid_i);
        i_n  = $signed(st_q.integ) + (err >>> KI_SH);
        if (i_n > half_i)       i_n = half_i;
        else if (i_n < -half_i) i_n = -half_i;
        p_n  = (err >>> KP_SH) + i_n;
        if (p_n > half_i)       p_n = half_i;
        else if (p_n < -half_i) p_n = -half_i;
        if (valley_i) begin
            st_d.integ = i_n;
            st_d.pi    = p_n;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pi_o = $signed(st_q.pi);

    // R7: the middle shift stays inside the carrier range after each update
    a_r7_pi_bounded: assert property (@(posedge clk) disable iff (rst)
        valley_i |=> (($signed(st_q.pi) <= $past(half_i)) &&
                      ($signed(st_q.pi) >= -$past(half_i))));
endmodule

// File: rtl/pwm4_mod.sv
module pwm4_mod
    import pwm4_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 12,
    parameter int KP_SH = 3,
    parameter int KI_SH = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CW-1:0]          carr_half,
    input  logic signed [DW-1:0]   ref_a,
    input  logic signed [DW-1:0]   ref_b,
    input  logic signed [DW-1:0]   ref_c,
    input  logic signed [DW-1:0]   v_up,
    input  logic signed [DW-1:0]   v_mid,
    input  logic signed [DW-1:0]   v_lo,
    input  logic signed [DW-1:0]   v_bus,
    output logic [NCP*NPH-1:0]     cmp_o,
    output logic [2*NPH-1:0]       lvl_o,
    output logic                   clip_o
);
    localparam int WW = DW + 4;

    typedef struct packed {
        logic [NPH-1:0][WW-1:0]  m;
        logic                    clip;
        logic [NPH-1:0][NCP-1:0] cmp;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0]        cnt;
    logic                 valley;
    logic signed [WW-1:0] half_s, one_s, tri_s, zs, pi_w;
    logic signed [WW-1:0] ref_w [NPH];
    logic signed [WW-1:0] m_new [NPH];
    logic signed [WW-1:0] m_q   [NPH];

    assign half_s   = $signed({{(WW-CW){1'b0}}, carr_half});
    assign one_s    = (half_s <<< 1) + half_s;
    assign tri_s    = ($signed({{(WW-CW){1'b0}}, cnt}) <<< 1) - half_s;
    assign ref_w[0] = {{(WW-DW){ref_a[DW-1]}}, ref_a};
    assign ref_w[1] = {{(WW-DW){ref_b[DW-1]}}, ref_b};
    assign ref_w[2] = {{(WW-DW){ref_c[DW-1]}}, ref_c};

    pwm4_carrier #(.CW(CW)) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .half_i   (carr_half),
        .cnt_o    (cnt),
        .valley_o (valley)
    );

    pwm4_zseq #(.WW(WW)) u_zseq (
        .ref_a_i (ref_w[0]),
        .ref_b_i (ref_w[1]),
        .ref_c_i (ref_w[2]),
        .v_up_i  ({{(WW-DW){v_up[DW-1]}}, v_up}),
        .v_lo_i  ({{(WW-DW){v_lo[DW-1]}}, v_lo}),
        .one_i   (one_s),
        .zs_o    (zs)
    );

    pwm4_pi #(.WW(WW), .KP_SH(KP_SH), .KI_SH(KI_SH)) u_pi (
        .clk      (clk),
        .rst      (rst),
        .valley_i (valley),
        .v_bus_i  ({{(WW-DW){v_bus[DW-1]}}, v_bus}),
        .v_mid_i  ({{(WW-DW){v_mid[DW-1]}}, v_mid}),
        .half_i   (half_s),
        .pi_o     (pi_w)
    );

    always_comb begin
        logic signed [WW-1:0] sum;
        logic signed [WW-1:0] pic;
        logic                 sat_any;
        st_d    = st_q;
        sat_any = 1'b0;
        for (int p = 0; p < NPH; p++) begin
            sum = ref_w[p] + zs;
            if (sum > one_s) begin
                m_new[p] = one_s;
                sat_any  = 1'b1;
            end else if (sum < -one_s) begin
                m_new[p] = -one_s;
                sat_any  = 1'b1;
            end else begin
                m_new[p] = sum;
            end
        end
        pic = pi_w;
        if (pic > half_s)       pic = half_s;
        else if (pic < -half_s) pic = -half_s;
        for (int p = 0; p < NPH; p++) begin
            st_d.cmp[p][0] = (m_q[p] + (half_s <<< 1)) > tri_s;
            st_d.cmp[p][1] = (m_q[p] + pic) > tri_s;
            st_d.cmp[p][2] = (m_q[p] - (half_s <<< 1)) > tri_s;
        end
        if (valley) begin
            for (int p = 0; p < NPH; p++) st_d.m[p] = m_new[p];
            st_d.clip = sat_any;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        for (int p = 0; p < NPH; p++) begin
            m_q[p] = $signed(st_q.m[p]);
            lvl_o[2*p +: 2] = 2'(st_q.cmp[p][0]) + 2'(st_q.cmp[p][1]) + 2'(st_q.cmp[p][2]);
        end
    end

    assign cmp_o  = st_q.cmp;
    assign clip_o = st_q.clip;

    // R9: reset clears the outputs on the next clock
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> ((cmp_o == '0) && (clip_o == 1'b0)));

    // R3: upper at or above lower puts one phase exactly on the positive rail
    a_r3_max_at_rail: assert property (@(posedge clk) disable iff (rst)
        (valley && (v_up >= v_lo)) |=>
        ((m_q[0] == $past(one_s)) || (m_q[1] == $past(one_s)) || (m_q[2] == $past(one_s))));

    // R4: upper below lower puts one phase exactly on the negative rail
    a_r4_min_at_rail: assert property (@(posedge clk) disable iff (rst)
        (valley && (v_up < v_lo)) |=>
        ((m_q[0] == -$past(one_s)) || (m_q[1] == -$past(one_s)) || (m_q[2] == -$past(one_s))));

    for (genvar g = 0; g < NPH; g++) begin : g_chk
        // R2: the three bits of a phase always form a thermometer code
        a_r2_thermometer: assert property (@(posedge clk) disable iff (rst)
            ((!cmp_o[3*g+2] || cmp_o[3*g+1]) && (!cmp_o[3*g+1] || cmp_o[3*g])));
        // R6: latched modulating signals stay within full scale
        a_r6_mod_in_range: assert property (@(posedge clk) disable iff (rst)
            valley |=> ((m_q[g] <= $past(one_s)) && (m_q[g] >= -$past(one_s))));
    end
endmodule

// File: tb/tb_pwm4_mod.sv
module tb_pwm4_mod;
    localparam int DW = 16;
    localparam int CW = 12;
    localparam int H  = 8;
    localparam int NV = 8;

    // stimulus: ref_a, ref_b, ref_c, v_up, v_lo (expected values come from model_mod)
    localparam int VEC [NV][5] = '{
        '{  0,   0,   0, 100, 100},
        '{  0,   0,   0,  90, 110},
        '{ 12,  -6,  -6, 120, 100},
        '{ 12,  -6,  -6,  80, 100},
        '{ 32, -32,   0, 100, 100},
        '{ -5,  20, -15,  70, 130},
        '{  3,  17, -20, 140,  60},
        '{ 40, -40,   0,  10, 200}
    };

    logic                 clk = 1'b0;
    logic                 rst;
    logic [CW-1:0]        carr_half;
    logic signed [DW-1:0] ref_a, ref_b, ref_c, v_up, v_mid, v_lo, v_bus;
    logic [8:0]           cmp_o;
    logic [5:0]           lvl_o;
    logic                 clip_o;

    always #5 clk = ~clk;

    pwm4_mod #(.DW(DW), .CW(CW), .KP_SH(2), .KI_SH(4)) dut (
        .clk(clk), .rst(rst), .carr_half(carr_half),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
        .v_up(v_up), .v_mid(v_mid), .v_lo(v_lo), .v_bus(v_bus),
        .cmp_o(cmp_o), .lvl_o(lvl_o), .clip_o(clip_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int hi_cnt [9];
    int lvl_bad;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1 R2: high cycles of a copy over one full carrier period
    function automatic int duty(input int copy);
        int n = 0;
        for (int c = 0; c <= H; c++) if (copy > 2*c - H) n++;
        for (int c = H-1; c >= 1; c--) if (copy > 2*c - H) n++;
        return n;
    endfunction

    // R3 R4 R5 R6: modulating signals from references and outer voltages
    task automatic model_mod(input int ra, input int rb, input int rc, input int up, input int lo,
                             output int m0, output int m1, output int m2, output bit clip);
        int one = 3*H;
        int mx, mn, zs;
        int s [3];
        mx = ra; if (rb > mx) mx = rb; if (rc > mx) mx = rc;
        mn = ra; if (rb < mn) mn = rb; if (rc < mn) mn = rc;
        zs = (up >= lo) ? one - mx : -one - mn;
        s[0] = ra + zs; s[1] = rb + zs; s[2] = rc + zs;
        clip = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (s[i] > one)  begin s[i] = one;  clip = 1'b1; end
            if (s[i] < -one) begin s[i] = -one; clip = 1'b1; end
        end
        m0 = s[0]; m1 = s[1]; m2 = s[2];
    endtask

    task automatic clear_acc();
        for (int i = 0; i < 9; i++) hi_cnt[i] = 0;
        lvl_bad = 0;
    endtask

    task automatic accum();
        for (int i = 0; i < 9; i++) if (cmp_o[i]) hi_cnt[i]++;
        for (int p = 0; p < 3; p++) begin
            // R10: level equals number of set comparator bits
            if (int'(lvl_o[2*p +: 2]) != int'(cmp_o[3*p]) + int'(cmp_o[3*p+1]) + int'(cmp_o[3*p+2]))
                lvl_bad++;
        end
    endtask

    task automatic compare_acc(input int m0, input int m1, input int m2, input int piv, input string tag);
        int m [3];
        int copy, e;
        m[0] = m0; m[1] = m1; m[2] = m2;
        for (int p = 0; p < 3; p++) begin
            for (int j = 0; j < 3; j++) begin
                copy = (j == 0) ? m[p] + 2*H : (j == 1) ? m[p] + piv : m[p] - 2*H;
                e = duty(copy);
                chk(hi_cnt[3*p+j] == e, $sformatf("R1 R2 %s bit %0d", tag, 3*p+j), hi_cnt[3*p+j], e);
            end
        end
        chk(lvl_bad == 0, $sformatf("R10 %s level mismatches", tag), lvl_bad, 0);
    endtask

    task automatic run_period(input int m0, input int m1, input int m2, input int piv, input string tag);
        clear_acc();
        repeat (2*H) begin
            @(posedge clk);
            @(negedge clk);
            accum();
        end
        compare_acc(m0, m1, m2, piv, tag);
    endtask

    task automatic set_in(input int ra, input int rb, input int rc, input int up, input int lo);
        ref_a = 16'(ra); ref_b = 16'(rb); ref_c = 16'(rc);
        v_up  = 16'(up); v_lo  = 16'(lo);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int m0, m1, m2;
        bit eclip;
        string tag;
        rst = 1'b1;
        carr_half = CW'(H);
        v_bus = 16'(300);
        v_mid = 16'(100);
        set_in(24, -24, 0, 100, 100);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: outputs low while in reset
        chk((cmp_o == 9'd0) && (lvl_o == 6'd0) && (clip_o == 1'b0), "R9 reset outputs", int'(cmp_o), 0);

        // R8: sample taken at first clock after reset; later changes ignored until next valley
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        set_in(-10, 5, 5, 50, 150);
        clear_acc();
        for (int k = 1; k <= 2*H; k++) begin
            @(posedge clk);
            @(negedge clk);
            accum();
            if (k == 2*H-2) set_in(24, -24, 0, 100, 100);
        end
        compare_acc(24, -24, 0, 0, "R8 hold between valleys");

        // R2 R3 R4 R5 R6: vector table
        for (int v = 0; v < NV; v++) begin
            set_in(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
            repeat (2*H+2) @(posedge clk);
            @(negedge clk);
            model_mod(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], m0, m1, m2, eclip);
            chk(clip_o == eclip, $sformatf("R6 clip flag vector %0d", v), int'(clip_o), int'(eclip));
            tag = (VEC[v][3] >= VEC[v][4]) ? $sformatf("R3 R5 vector %0d", v)
                                           : $sformatf("R4 R5 vector %0d", v);
            run_period(m0, m1, m2, 0, tag);
        end

        // R7: positive error drives middle shift to +H
        set_in(24, -24, 0, 100, 100);
        v_mid = 16'(0);
        repeat (8*H) @(posedge clk);
        @(negedge clk);
        run_period(24, -24, 0, H, "R7 positive error");

        // R7: zero error, integrator holds +H
        v_mid = 16'(100);
        repeat (6*H) @(posedge clk);
        @(negedge clk);
        run_period(24, -24, 0, H, "R7 integrator hold");

        // R7: negative error drives middle shift to -H
        v_mid = 16'(200);
        repeat (6*H) @(posedge clk);
        @(negedge clk);
        run_period(24, -24, 0, -H, "R7 negative error");

        // R9: reset mid-run clears outputs and integrator
        rst = 1'b1;
        v_mid = 16'(100);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk((cmp_o == 9'd0) && (lvl_o == 6'd0) && (clip_o == 1'b0), "R9 reset mid-run", int'(cmp_o), 0);
        rst = 1'b0;
        repeat (6*H) @(posedge clk);
        @(negedge clk);
        run_period(24, -24, 0, 0, "R9 integrator cleared");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule